// File: doc/BRIEF.md
# Relocatable Protected Multi-Bank SRAM

This block is an on-chip data memory made of four independent 1-Kbyte SRAM banks behind one internal bus slave port. Each bank has its own configuration register. The register holds a base address, which can be any 1-Kbyte boundary of the 32-bit address space, an enable bit, a supervisor-only attribute and a write-protect attribute. Every bus request is compared against all enabled banks.

When a request hits a bank and passes that bank's privilege and write-protect checks, the block claims the transfer. It raises `extSuppress` in the same cycle so that the external address strobe and any chip select decoded for that address stay inactive. It then completes the transfer with a fixed two-clock timing. A request that fails a check is not claimed, leaves memory untouched and does not suppress the external bus.

Reads always return the full 32-bit word. Writes merge only the byte lanes selected by the access size and the low address bits, in big-endian lane order. If two enabled banks are placed on the same 1-Kbyte window, the read data is undefined.

Top module: `reloc_sram_banks`

## Requirements
- R1: A configuration write with `cfgWrEn` high stores `cfgWrData` into the register of bank `cfgSel` as follows: bits [31:10] are the base, bit 0 is enable, bit 1 is supervisor-only and bit 2 is write-protect. `cfgRdData` returns the selected bank's register in that layout, with bits [9:3] reading zero.
- R2: After reset every bank register reads zero and all banks are disabled. `busAck` and `extSuppress` are low, and no request is claimed.
- R3: A request is claimed only when `busAddr[31:10]` equals the base of an enabled bank. A disabled bank never claims, and it keeps its contents until it is enabled again.
- R4: A claimed request, sampled with `busStart` high, is acknowledged by `busAck` for exactly one cycle, in the clock that follows. Unclaimed requests produce no `busAck`.
- R5: A read returns the full 32-bit word at `busAddr[9:2]` on `busRData` in the `busAck` cycle, whatever `busSize` says.
- R6: `busSize` encodes 0 as long word, 1 as byte, 2 as 16-bit word and 3 as three bytes. Lane 3 is `busWData[31:24]` and corresponds to address offset 0; lane 0 is bits [7:0] and offset 3. A write sets the lanes of its size starting at offset `busAddr[1:0]`. Lanes that would fall past offset 3 are dropped, and all other lanes keep their contents.
- R7: A request with `busSuper` low to a supervisor-only bank is not claimed. It does not change memory and does not raise `extSuppress` or `busAck`.
- R8: A write to a write-protected bank is not claimed and changes nothing. Reads of that bank are still claimed.
- R9: `extSuppress` is high in the request cycle of a claimed request, because it is decoded from the inputs in that same cycle, and it stays high in its `busAck` cycle. It is low otherwise.
- R10: A `busStart` that arrives during a `busAck` cycle is ignored. It performs no access and gets no acknowledge.
- R11: Each bank has its own storage. Moving a bank to a new base makes its existing contents visible at the new window, and the old window no longer hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration register write enable |
| cfgSel | input | 2 | Bank selected for configuration write and read-back |
| cfgWrData | input | 32 | Configuration write value |
| cfgRdData | output | 32 | Read-back of the selected bank register |
| busStart | input | 1 | Request valid this cycle |
| busAddr | input | 32 | Byte address of the request |
| busWrite | input | 1 | 1 for write, 0 for read |
| busSize | input | 2 | Access size code |
| busSuper | input | 1 | 1 for supervisor privilege |
| busWData | input | 32 | Write data, lane-positioned |
| busRData | output | 32 | Read data, valid with busAck |
| busAck | output | 1 | Transfer termination, one cycle after a claimed request |
| extSuppress | output | 1 | Suppresses the external strobe and chip selects |

## Verification
Some properties hold on every cycle and are checked by the assertions. A claimed request always leads to a single acknowledge cycle. `extSuppress` covers the acknowledge cycle. No selected bank is ever disabled, is a supervisor-only bank hit by a user request, or is write-protected for a write. Every write carries at least one lane. The data side cannot be checked that way: lane merging for each size and offset, full-word reads, preserved contents after refused writes, contents that follow a relocated bank, and dropped back-to-back requests are shown only by the bench's scenarios, which read memory back through the bus.

// File: rtl/reloc_sram_pkg.sv
package reloc_sram_pkg;

  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int NUM_BANKS  = 4;
  localparam int BANK_BYTES = 1024;

  localparam int LANES  = DATA_W / 8;
  localparam int OFS_W  = $clog2(BANK_BYTES);
  localparam int LANE_W = $clog2(LANES);
  localparam int IDX_W  = OFS_W - LANE_W;
  localparam int WORDS  = BANK_BYTES / LANES;
  localparam int BASE_W = ADDR_W - OFS_W;
  localparam int SEL_W  = $clog2(NUM_BANKS);
  localparam int PAD_W  = OFS_W - 3;

  typedef enum logic [1:0] {
    SZ_LONG   = 2'd0,
    SZ_BYTE   = 2'd1,
    SZ_WORD   = 2'd2,
    SZ_TRIPLE = 2'd3
  } accSize_e;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic              enable;
    logic              superOnly;
    logic              wrProt;
  } bankCfg_t;

  typedef struct packed {
    logic [NUM_BANKS-1:0] bankSel;
    logic                 wrEn;
    logic                 rdEn;
    logic [LANES-1:0]     laneMask;
    logic [IDX_W-1:0]     wordIdx;
  } memStrobe_t;

  // Big-endian lane mask: offset 0 is the most significant lane.
  function automatic logic [LANES-1:0] laneMaskFor(input accSize_e size,
                                                   input logic [LANE_W-1:0] lo);
    int span;
    logic [LANES-1:0] m;
    case (size)
      SZ_BYTE:   span = 1;
      SZ_WORD:   span = 2;
      SZ_TRIPLE: span = 3;
      default:   span = LANES;
    endcase
    m = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < span) m[LANES-1-i] = 1'b1;
    end
    if (size == SZ_LONG) return m;
    return m >> lo;
  endfunction

endpackage

// File: rtl/bank_decoder.sv
module bank_decoder
  import reloc_sram_pkg::*;
(
  input  bankCfg_t          cfg,
  input  logic [BASE_W-1:0] addrHi,
  input  logic              isSuper,
  input  logic              isWrite,
  output logic              hit
);

  logic windowMatch;
  logic privOk;
  logic protOk;

  always_comb begin
    windowMatch = cfg.enable && (addrHi == cfg.base);
    privOk      = isSuper || !cfg.superOnly;
    protOk      = !(isWrite && cfg.wrProt);
    hit         = windowMatch && privOk && protOk;
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import reloc_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic [DATA_W-1:0] cfgRdData,
  input  logic              busStart,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic              busSuper,
  output logic              busAck,
  output logic              extSuppress,
  output memStrobe_t        strobe
);

  bankCfg_t [NUM_BANKS-1:0] cfgVec;
  logic     [NUM_BANKS-1:0] hitVec;
  logic                     accept;
  logic                     ackQ;
  logic                     unusedCfgBits;

  assign unusedCfgBits = ^cfgWrData[OFS_W-1:3];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bankCfg_t cfgQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ <= '0;
      end else if (cfgWrEn && (cfgSel == SEL_W'(b))) begin
        cfgQ.base      <= cfgWrData[ADDR_W-1:OFS_W];
        cfgQ.enable    <= cfgWrData[0];
        cfgQ.superOnly <= cfgWrData[1];
        cfgQ.wrProt    <= cfgWrData[2];
      end
    end

    assign cfgVec[b] = cfgQ;

    bank_decoder i_bank_decoder (
      .cfg     (cfgQ),
      .addrHi  (busAddr[ADDR_W-1:OFS_W]),
      .isSuper (busSuper),
      .isWrite (busWrite),
      .hit     (hitVec[b])
    );

    AST_SEL_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rstN)
      strobe.bankSel[b] |-> cfgQ.enable); // R3
    AST_USER_NOT_IN_SUPER_BANK: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.bankSel[b] && !busSuper) |-> !cfgQ.superOnly); // R7
    AST_NO_WRITE_TO_PROTECTED: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.bankSel[b] && strobe.wrEn) |-> !cfgQ.wrProt); // R8
  end

  always_comb begin
    cfgRdData = {cfgVec[cfgSel].base, {PAD_W{1'b0}},
                 cfgVec[cfgSel].wrProt, cfgVec[cfgSel].superOnly,
                 cfgVec[cfgSel].enable};
  end

  // A request is taken only outside the acknowledge cycle.
  assign accept = busStart && !ackQ && (|hitVec);

  always_comb begin
    strobe.bankSel  = accept ? hitVec : '0;
    strobe.wrEn     = accept && busWrite;
    strobe.rdEn     = accept && !busWrite;
    strobe.laneMask = laneMaskFor(accSize_e'(busSize), busAddr[LANE_W-1:0]);
    strobe.wordIdx  = busAddr[OFS_W-1:LANE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= accept;
  end

  assign busAck      = ackQ;
  assign extSuppress = accept || ackQ;

  AST_ACK_FOLLOWS_CLAIM: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe.bankSel) |=> busAck); // R4
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck); // R4
  AST_SUPPRESS_COVERS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    busAck |-> extSuppress); // R9
  AST_START_IN_ACK_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (busStart && busAck) |-> (strobe.bankSel == '0)); // R10

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import reloc_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData
);

  logic [NUM_BANKS-1:0][DATA_W-1:0] bankOut;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mem
    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] rdQ;
    logic              selQ;

    always_ff @(posedge clk) begin
      if (strobe.wrEn && strobe.bankSel[b]) begin
        for (int l = 0; l < LANES; l++) begin
          if (strobe.laneMask[l]) begin
            mem[strobe.wordIdx][l*8 +: 8] <= busWData[l*8 +: 8];
          end
        end
      end
      if (strobe.rdEn && strobe.bankSel[b]) begin
        rdQ <= mem[strobe.wordIdx];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) selQ <= 1'b0;
      else       selQ <= strobe.rdEn && strobe.bankSel[b];
    end

    assign bankOut[b] = selQ ? rdQ : '0;
  end

  always_comb begin
    busRData = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      busRData = busRData | bankOut[b];
    end
  end

  AST_WRITE_HAS_LANE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (strobe.laneMask != '0)); // R6
  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrEn && strobe.rdEn)); // R5

endmodule

// File: rtl/reloc_sram_banks.sv
module reloc_sram_banks
  import reloc_sram_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgSel,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  input  logic        busStart,
  input  logic [31:0] busAddr,
  input  logic        busWrite,
  input  logic [1:0]  busSize,
  input  logic        busSuper,
  input  logic [31:0] busWData,
  output logic [31:0] busRData,
  output logic        busAck,
  output logic        extSuppress
);

  memStrobe_t strobe;

  sram_ctrl i_sram_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWrEn     (cfgWrEn),
    .cfgSel      (cfgSel),
    .cfgWrData   (cfgWrData),
    .cfgRdData   (cfgRdData),
    .busStart    (busStart),
    .busAddr     (busAddr),
    .busWrite    (busWrite),
    .busSize     (busSize),
    .busSuper    (busSuper),
    .busAck      (busAck),
    .extSuppress (extSuppress),
    .strobe      (strobe)
  );

  sram_datapath i_sram_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWData (busWData),
    .busRData (busRData)
  );

endmodule

// File: tb/test_reloc_sram_banks.sv
`timescale 1ns/1ps
module test_reloc_sram_banks;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        busStart = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busWrite = 1'b0;
  logic [1:0]  busSize = '0;
  logic        busSuper = 1'b0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        busAck;
  logic        extSuppress;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reloc_sram_banks i_reloc_sram_banks (.*);

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic        sup;
    logic [31:0] addr;
    logic [31:0] wd;
    logic        hit;
    logic        chkRd;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd0, 1'b0, 32'h0000_1000, 32'h1122_3344, 1'b1, 1'b0, 32'h0},
    '{1'b0, 2'd0, 1'b0, 32'h0000_1000, 32'h0,         1'b1, 1'b1, 32'h1122_3344},
    '{1'b1, 2'd1, 1'b1, 32'h0000_1001, 32'hA5A5_A5A5, 1'b1, 1'b0, 32'h0},
    '{1'b0, 2'd1, 1'b0, 32'h0000_1003, 32'h0,         1'b1, 1'b1, 32'h11A5_3344},
    '{1'b1, 2'd2, 1'b1, 32'h0000_1002, 32'hBEEF_BEEF, 1'b1, 1'b0, 32'h0},
    '{1'b0, 2'd2, 1'b1, 32'h0000_1000, 32'h0,         1'b1, 1'b1, 32'h11A5_BEEF},
    '{1'b1, 2'd3, 1'b0, 32'h0000_1001, 32'h00CC_DDEE, 1'b1, 1'b0, 32'h0},
    '{1'b0, 2'd0, 1'b1, 32'h0000_1000, 32'h0,         1'b1, 1'b1, 32'h11CC_DDEE},
    '{1'b1, 2'd0, 1'b1, 32'h0000_1004, 32'h0102_0304, 1'b1, 1'b0, 32'h0},
    '{1'b1, 2'd3, 1'b1, 32'h0000_1004, 32'h7766_5544, 1'b1, 1'b0, 32'h0},
    '{1'b0, 2'd0, 1'b0, 32'h0000_1004, 32'h0,         1'b1, 1'b1, 32'h7766_5504},
    '{1'b1, 2'd3, 1'b1, 32'h0000_1006, 32'hAABB_CCDD, 1'b1, 1'b0, 32'h0},
    '{1'b0, 2'd0, 1'b0, 32'h0000_1004, 32'h0,         1'b1, 1'b1, 32'h7766_CCDD},
    '{1'b1, 2'd0, 1'b1, 32'h8000_0400, 32'hCAFE_F00D, 1'b1, 1'b0, 32'h0},
    '{1'b1, 2'd0, 1'b0, 32'h8000_0400, 32'h1234_5678, 1'b0, 1'b0, 32'h0},
    '{1'b0, 2'd0, 1'b0, 32'h8000_0400, 32'h0,         1'b0, 1'b0, 32'h0},
    '{1'b0, 2'd0, 1'b1, 32'h8000_0400, 32'h0,         1'b1, 1'b1, 32'hCAFE_F00D},
    '{1'b1, 2'd0, 1'b1, 32'h0000_13FC, 32'hDEAD_BEEF, 1'b1, 1'b0, 32'h0},
    '{1'b0, 2'd0, 1'b0, 32'h0000_13FC, 32'h0,         1'b1, 1'b1, 32'hDEAD_BEEF},
    '{1'b0, 2'd0, 1'b1, 32'h0000_1400, 32'h0,         1'b0, 1'b0, 32'h0},
    '{1'b0, 2'd0, 1'b1, 32'h0000_2000, 32'h0,         1'b0, 1'b0, 32'h0},
    '{1'b1, 2'd0, 1'b0, 32'hFFFF_FC08, 32'h0BAD_C0DE, 1'b1, 1'b0, 32'h0},
    '{1'b0, 2'd0, 1'b0, 32'hFFFF_FC08, 32'h0,         1'b1, 1'b1, 32'h0BAD_C0DE}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = val;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgCheck(input logic [1:0] sel, input logic [31:0] exp, input string req);
    cfgSel = sel;
    #1;
    chk(req, cfgRdData, exp);
  endtask

  task automatic busOp(input logic wr, input logic [1:0] sz, input logic sup,
                       input logic [31:0] addr, input logic [31:0] wd,
                       input logic expHit, input logic chkRd,
                       input logic [31:0] expRd, input string req);
    @(negedge clk);
    busWrite = wr; busSize = sz; busSuper = sup; busAddr = addr; busWData = wd;
    busStart = 1'b1;
    #1;
    chk({req, " R9 suppress in request cycle"}, {31'b0, extSuppress}, {31'b0, expHit});
    @(negedge clk);
    busStart = 1'b0;
    chk({req, " R4 ack"}, {31'b0, busAck}, {31'b0, expHit});
    chk({req, " R9 suppress in ack cycle"}, {31'b0, extSuppress}, {31'b0, expHit});
    if (chkRd && expHit) chk({req, " R5 read data"}, busRData, expRd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 ack after reset", {31'b0, busAck}, 32'd0);
    chk("R2 suppress after reset", {31'b0, extSuppress}, 32'd0);
    rstN = 1'b1;
    for (int b = 0; b < 4; b++) cfgCheck(2'(b), 32'h0, "R2 bank register clear");
    busOp(1'b0, 2'd0, 1'b1, 32'h0000_0000, 32'h0, 1'b0, 1'b0, 32'h0, "R2 disabled bank at base 0");

    // R1: configuration
    cfgWrite(2'd0, 32'h0000_1001);
    cfgWrite(2'd1, 32'h8000_0403);
    cfgWrite(2'd2, 32'hFFFF_FC01);
    cfgWrite(2'd3, 32'h0000_2000);
    cfgCheck(2'd1, 32'h8000_0403, "R1 bank1 read-back");
    cfgWrite(2'd3, 32'h4000_0FF9);
    cfgCheck(2'd3, 32'h4000_0C01, "R1 bits 9:3 read zero");
    cfgWrite(2'd3, 32'h0000_2000);
    cfgCheck(2'd3, 32'h0000_2000, "R1 bank3 disabled");

    // Table walk: R3 R5 R6 R7 R11
    for (int i = 0; i < NV; i++) begin
      busOp(TBL[i].wr, TBL[i].sz, TBL[i].sup, TBL[i].addr, TBL[i].wd,
            TBL[i].hit, TBL[i].chkRd, TBL[i].rd, $sformatf("vec%0d R3/R6/R7", i));
    end

    // R8: write-protect
    cfgWrite(2'd2, 32'hFFFF_FC05);
    busOp(1'b1, 2'd0, 1'b1, 32'hFFFF_FC08, 32'h1111_1111, 1'b0, 1'b0, 32'h0, "R8 protected long write");
    busOp(1'b1, 2'd1, 1'b1, 32'hFFFF_FC09, 32'h2222_2222, 1'b0, 1'b0, 32'h0, "R8 protected byte write");
    busOp(1'b0, 2'd0, 1'b0, 32'hFFFF_FC08, 32'h0, 1'b1, 1'b1, 32'h0BAD_C0DE, "R8 protected read");

    // R10: start during ack cycle is dropped
    @(negedge clk);
    busWrite = 1'b1; busSize = 2'd0; busSuper = 1'b1;
    busAddr = 32'h0000_1008; busWData = 32'h5555_5555; busStart = 1'b1;
    @(negedge clk);
    chk("R10 first ack", {31'b0, busAck}, 32'd1);
    busWData = 32'h6666_6666;
    @(negedge clk);
    busStart = 1'b0;
    chk("R10 no ack for dropped start", {31'b0, busAck}, 32'd0);
    busOp(1'b0, 2'd0, 1'b1, 32'h0000_1008, 32'h0, 1'b1, 1'b1, 32'h5555_5555, "R10 dropped write");

    // R11: relocation keeps contents
    cfgWrite(2'd0, 32'h4000_0001);
    busOp(1'b0, 2'd0, 1'b0, 32'h4000_0000, 32'h0, 1'b1, 1'b1, 32'h11CC_DDEE, "R11 new window");
    busOp(1'b0, 2'd0, 1'b0, 32'h0000_1000, 32'h0, 1'b0, 1'b0, 32'h0, "R11 old window");

    // R3: disable then re-enable
    cfgWrite(2'd1, 32'h8000_0402);
    busOp(1'b0, 2'd0, 1'b1, 32'h8000_0400, 32'h0, 1'b0, 1'b0, 32'h0, "R3 disabled bank");
    cfgWrite(2'd1, 32'h8000_0403);
    busOp(1'b0, 2'd0, 1'b1, 32'h8000_0400, 32'h0, 1'b1, 1'b1, 32'hCAFE_F00D, "R3 re-enabled contents");

    // R6: three-byte write at offset 2 drops the lane past offset 3
    busOp(1'b1, 2'd3, 1'b0, 32'h4000_0002, 32'h0102_0304, 1'b1, 1'b0, 32'h0, "R6 triple offset 2");
    busOp(1'b0, 2'd0, 1'b0, 32'h4000_0000, 32'h0, 1'b1, 1'b1, 32'h11CC_0304, "R6 triple offset 2 readback");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule